// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Mode

This block is a first-in first-out buffer whose write side and read side run on independent clocks. Words are 18 bits wide by default, and the depth is a power-of-two parameter. Pointers cross between the two clock domains as Gray code through a chain of synchronizer flops. Because of this, the local flags react at once to local activity and react a few cycles late to activity in the other domain.

A mode input is captured while master reset is held low and stays fixed until the next master reset. In standard mode, a word is read by driving the read enable low, and the two status outputs act as an empty flag and a full flag. In fall-through mode, the first word that enters an empty buffer moves to the output on its own, and the two status outputs act as output-valid and input-ready.

Partial reset empties the buffer and keeps the mode. A retransmit strobe rewinds the read pointer to the first location so that stored data can be read again. A half-full flag and an occupancy count on each side let an external threshold unit derive almost-empty and almost-full conditions.

Top module: `dcf_fifo`

## Requirements
- R1: The timing mode is sampled from `mode_sel` (0 = standard, 1 = fall-through) on clock edges while `mrst_n` is low. After that it does not change until the next master reset; partial reset and later changes of `mode_sel` have no effect on it.
- R2: In standard mode, a read clock edge with `rd_en_n` low and the buffer not empty places the oldest word on `dout` and removes it from the buffer. `rd_stat` is 1 exactly when the read side sees no stored word.
- R3: In fall-through mode, a word written into an empty buffer appears on `dout` with `rd_stat` = 1 after the third rising read clock edge that follows the write edge, with `rd_en_n` held high the whole time.
- R4: In fall-through mode, a presented word stays on `dout` while `rd_en_n` is high. A read edge with `rd_en_n` low consumes it and presents the next word, or drops `rd_stat` to 0 when no further word is stored.
- R5: `wr_stat` is 1 when the buffer is full in standard mode. In fall-through mode it is 1 when the buffer can accept a word (input ready).
- R6: A write attempted while the buffer is full is ignored. No stored word is overwritten and the occupancy does not grow.
- R7: In standard mode, a read attempted while the buffer is empty is ignored. `dout` keeps its previous value and the read pointer does not move.
- R8: `half_full` is 1 exactly when the write-side occupancy is greater than DEPTH/2. It updates on the write clock edge that changes the occupancy.
- R9: Master reset empties the buffer. After it, `wr_level` and `rd_level` are 0, `half_full` is 0, and the status flags show the empty and not-full state of the selected mode.
- R10: Partial reset empties the buffer, clears any presented word and keeps the timing mode.
- R11: A read clock edge with `rt_n` low sets the read pointer back to the first memory location, so that the words written since the last reset are read again in order.
- R12: `wr_level` (write domain) and `rd_level` (read domain) report the number of words in memory once both domains have settled, and never exceed DEPTH. A word held on the fall-through output is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low; clears pointers and samples the mode |
| prst_n | input | 1 | Partial reset, active low; clears pointers and keeps the mode |
| mode_sel | input | 1 | Timing mode sampled during master reset: 0 standard, 1 fall-through |
| wr_en_n | input | 1 | Write enable, active low |
| din | input | WIDTH | Write data |
| wr_stat | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | Occupancy above half of the depth |
| wr_level | output | $clog2(DEPTH)+1 | Occupancy seen by the write domain |
| rd_en_n | input | 1 | Read enable, active low |
| rt_n | input | 1 | Retransmit strobe, active low |
| dout | output | WIDTH | Read data |
| rd_stat | output | 1 | Empty (standard) or output valid (fall-through) |
| rd_level | output | $clog2(DEPTH)+1 | Occupancy seen by the read domain |

## Verification
The embedded properties check four things on every cycle. A write into a full buffer and a read from an empty buffer leave the pointers untouched. A fall-through word is held until it is consumed. The write-side occupancy never exceeds the depth. The latched mode stays constant outside master reset. Other behaviour can only be shown through bench scenarios: the exact three-edge fall-through latency, the data order across both domains, replay after retransmit, keeping the mode across a partial reset, and the half-full threshold. Random traffic in both modes compares every word read against a queue model.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FWFT = 1'b1
   } dcf_mode_e;

   localparam int DCF_WIDTH_DEF = 18;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dcf_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("dcf_sync: W must be at least 1");
   end

   logic [W-1:0] st [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= '0;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[g] <= '0;
            else        st[g] <= st[g-1];
         end
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_n,
   input  logic [AW:0]   rgray_s,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [AW:0]   wgray,
   output logic          full,
   output logic          half,
   output logic [AW:0]   level
);
   localparam int          DEPTH    = 1 << AW;
   localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);
   localparam logic [AW:0] HALF_LVL = (AW+1)'(DEPTH / 2);

   function automatic logic [AW:0] g2b(input logic [AW:0] g);
      logic [AW:0] b;
      b[AW] = g[AW];
      for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [AW:0] wbin, wbin_nx, rbin_s;

   assign rbin_s  = g2b(rgray_s);
   assign level   = wbin - rbin_s;
   assign full    = (level == FULL_LVL);
   assign half    = (level > HALF_LVL);
   assign we      = !wr_en_n && !full;
   assign wbin_nx = wbin + 1'b1;
   assign waddr   = wbin[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (we) begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_n && full) |=> $stable(wbin));

   assert_level_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
      level <= FULL_LVL);
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
   parameter int AW    = 4,
   parameter int WIDTH = 18
) (
   input  logic               clk,
   input  logic               rst_n,
   input  dcf_pkg::dcf_mode_e mode,
   input  logic               rd_en_n,
   input  logic               rt_n,
   input  logic [AW:0]        wgray_s,
   input  logic [WIDTH-1:0]   mem_q,
   output logic [AW-1:0]      raddr,
   output logic [AW:0]        rgray,
   output logic [WIDTH-1:0]   dout,
   output logic               rd_stat,
   output logic [AW:0]        level
);
   import dcf_pkg::*;

   function automatic logic [AW:0] g2b(input logic [AW:0] g);
      logic [AW:0] b;
      b[AW] = g[AW];
      for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [AW:0] rbin, rbin_nx, wbin_s;
   logic        mem_empty, is_fwft, ovalid, consume, pop;

   assign wbin_s    = g2b(wgray_s);
   assign level     = wbin_s - rbin;
   assign mem_empty = (level == '0);
   assign is_fwft   = (mode == MODE_FWFT);
   assign consume   = ovalid && !rd_en_n;
   assign pop       = is_fwft ? (!mem_empty && (!ovalid || consume))
                              : (!rd_en_n && !mem_empty);
   assign rbin_nx   = rbin + 1'b1;
   assign raddr     = rbin[AW-1:0];
   assign rd_stat   = is_fwft ? ovalid : mem_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin   <= '0;
         rgray  <= '0;
         ovalid <= 1'b0;
         dout   <= '0;
      end else if (!rt_n) begin
         rbin   <= '0;
         rgray  <= '0;
         ovalid <= 1'b0;
      end else begin
         if (pop) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
            dout  <= mem_q;
         end
         ovalid <= is_fwft && (pop || (ovalid && !consume));
      end
   end

   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_fwft && !rd_en_n && mem_empty && rt_n) |=> $stable(rbin));

   assert_fwft_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_fwft && ovalid && rd_en_n && rt_n) |=> (ovalid && $stable(dout)));
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
   parameter int WIDTH       = dcf_pkg::DCF_WIDTH_DEF,
   parameter int DEPTH       = 1024,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(DEPTH)
) (
   input  logic             wclk,
   input  logic             rclk,
   input  logic             mrst_n,
   input  logic             prst_n,
   input  logic             mode_sel,
   input  logic             wr_en_n,
   input  logic [WIDTH-1:0] din,
   output logic             wr_stat,
   output logic             half_full,
   output logic [AW:0]      wr_level,
   input  logic             rd_en_n,
   input  logic             rt_n,
   output logic [WIDTH-1:0] dout,
   output logic             rd_stat,
   output logic [AW:0]      rd_level
);
   import dcf_pkg::*;

   if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("dcf_fifo: DEPTH must be a power of two of at least 4");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("dcf_fifo: WIDTH must be at least 1");
   end

   logic             ptr_rst_n;
   dcf_mode_e        mode_w, mode_r;
   logic             we, full;
   logic [AW-1:0]    waddr, raddr;
   logic [AW:0]      wgray, rgray, wgray_s, rgray_s;
   logic [WIDTH-1:0] mem [DEPTH];
   logic [WIDTH-1:0] mem_q;

   assign ptr_rst_n = mrst_n & prst_n;

   always_ff @(posedge wclk) begin
      if (!mrst_n) mode_w <= dcf_mode_e'(mode_sel);
   end

   always_ff @(posedge rclk) begin
      if (!mrst_n) mode_r <= dcf_mode_e'(mode_sel);
   end

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= din;
   end
   assign mem_q = mem[raddr];

   dcf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk(rclk), .rst_n(ptr_rst_n), .d(wgray), .q(wgray_s));

   dcf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk(wclk), .rst_n(ptr_rst_n), .d(rgray), .q(rgray_s));

   dcf_wr_side #(.AW(AW)) u_wr (
      .clk(wclk), .rst_n(ptr_rst_n), .wr_en_n(wr_en_n), .rgray_s(rgray_s),
      .we(we), .waddr(waddr), .wgray(wgray), .full(full), .half(half_full),
      .level(wr_level));

   dcf_rd_side #(.AW(AW), .WIDTH(WIDTH)) u_rd (
      .clk(rclk), .rst_n(ptr_rst_n), .mode(mode_r), .rd_en_n(rd_en_n),
      .rt_n(rt_n), .wgray_s(wgray_s), .mem_q(mem_q), .raddr(raddr),
      .rgray(rgray), .dout(dout), .rd_stat(rd_stat), .level(rd_level));

   assign wr_stat = (mode_w == MODE_FWFT) ? !full : full;

   assert_mode_fixed_R1: assert property (@(posedge rclk) disable iff (!mrst_n)
      $stable(mode_r));
endmodule

// File: tb/tb_dcf_fifo.sv
module tb_dcf_fifo;
   localparam int CLK_PERIOD  = 10;
   localparam int RCLK_PERIOD = 16;
   localparam int DEPTH       = 16;
   localparam int WIDTH       = 18;
   localparam int AW          = $clog2(DEPTH);

   logic             wclk = 1'b0, rclk = 1'b0;
   logic             mrst_n = 1'b0, prst_n = 1'b1, mode_sel = 1'b0;
   logic             wr_en_n = 1'b1, rd_en_n = 1'b1, rt_n = 1'b1;
   logic [WIDTH-1:0] din = '0;
   logic             wr_stat, half_full, rd_stat;
   logic [AW:0]      wr_level, rd_level;
   logic [WIDTH-1:0] dout;

   int n_chk = 0, n_fail = 0;
   logic [WIDTH-1:0] q [$];
   bit wdone, pending;

   dcf_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (
      .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
      .mode_sel(mode_sel), .wr_en_n(wr_en_n), .din(din), .wr_stat(wr_stat),
      .half_full(half_full), .wr_level(wr_level), .rd_en_n(rd_en_n),
      .rt_n(rt_n), .dout(dout), .rd_stat(rd_stat), .rd_level(rd_level));

   always #(CLK_PERIOD/2)  wclk = ~wclk;
   always #(RCLK_PERIOD/2) rclk = ~rclk;

   function automatic logic [WIDTH-1:0] pat(input int i);
      return WIDTH'(i * 37 + 5) ^ 18'h2A5A5;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_mrst(input logic m);
      mrst_n = 1'b0; mode_sel = m;
      repeat (4) @(negedge rclk);
      mrst_n = 1'b1;
      repeat (2) @(negedge rclk);
   endtask

   task automatic do_prst(input logic m);
      prst_n = 1'b0; mode_sel = m;
      repeat (3) @(negedge rclk);
      prst_n = 1'b1;
      repeat (2) @(negedge rclk);
   endtask

   task automatic wr_word(input logic [WIDTH-1:0] d);
      @(negedge wclk); wr_en_n = 1'b0; din = d;
      @(negedge wclk); wr_en_n = 1'b1;
   endtask

   task automatic rd_pulse();
      @(negedge rclk); rd_en_n = 1'b0;
      @(negedge rclk); rd_en_n = 1'b1;
   endtask

   task automatic settle();
      repeat (6) @(negedge rclk);
   endtask

   task automatic rand_run(input bit fwft);
      wdone = 0; pending = 0;
      fork
         begin
            for (int i = 0; i < 300; i++) begin
               @(negedge wclk);
               if ($urandom % 10 < 6) begin
                  logic [WIDTH-1:0] d;
                  d = WIDTH'($urandom);
                  wr_en_n = 1'b0; din = d;
                  if (fwft ? wr_stat : !wr_stat) q.push_back(d);
               end else wr_en_n = 1'b1;
            end
            @(negedge wclk); wr_en_n = 1'b1;
            wdone = 1;
         end
         begin
            for (int g = 0; g < 20000; g++) begin
               @(negedge rclk);
               if (!fwft) begin
                  if (pending) begin
                     logic [WIDTH-1:0] e;
                     e = q.pop_front();
                     chk(dout == e, "R2", 32'(dout), 32'(e));
                     pending = 0;
                  end
                  if (!rd_stat && q.size() > 0 && ($urandom % 2 == 1)) begin
                     rd_en_n = 1'b0; pending = 1;
                  end else rd_en_n = 1'b1;
               end else begin
                  if (rd_stat && q.size() > 0) begin
                     chk(dout == q[0], "R4", 32'(dout), 32'(q[0]));
                     if ($urandom % 2 == 1) begin
                        rd_en_n = 1'b0; void'(q.pop_front());
                     end else rd_en_n = 1'b1;
                  end else rd_en_n = 1'b1;
               end
               if (wdone && q.size() == 0 && !pending) break;
            end
            rd_en_n = 1'b1;
         end
      join
      settle();
      chk(rd_level == 0, fwft ? "R4" : "R2", 32'(rd_level), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int n;
      void'($urandom(32'd4242));

      // R9: reset state in standard mode
      do_mrst(1'b0);
      chk(rd_stat == 1'b1, "R9", 32'(rd_stat), 1);
      chk(wr_stat == 1'b0, "R9", 32'(wr_stat), 0);
      chk(wr_level == 0 && rd_level == 0, "R9", 32'(wr_level), 0);
      chk(half_full == 1'b0, "R9", 32'(half_full), 0);

      // R12 / R2: levels and ordered reads
      for (int i = 0; i < 5; i++) wr_word(pat(i));
      settle();
      chk(wr_level == 5, "R12", 32'(wr_level), 5);
      chk(rd_level == 5, "R12", 32'(rd_level), 5);
      chk(rd_stat == 1'b0, "R2", 32'(rd_stat), 0);
      for (int i = 0; i < 5; i++) begin
         rd_pulse();
         chk(dout == pat(i), "R2", 32'(dout), 32'(pat(i)));
      end
      settle();
      chk(rd_stat == 1'b1, "R2", 32'(rd_stat), 1);

      // R7: read while empty ignored
      rd_pulse();
      chk(dout == pat(4), "R7", 32'(dout), 32'(pat(4)));
      chk(rd_level == 0, "R7", 32'(rd_level), 0);
      wr_word(pat(100));
      settle();
      rd_pulse();
      chk(dout == pat(100), "R7", 32'(dout), 32'(pat(100)));

      // R8 / R5 / R6: half, full, overflow
      do_mrst(1'b0);
      for (int i = 0; i < DEPTH/2; i++) wr_word(pat(10 + i));
      chk(half_full == 1'b0, "R8", 32'(half_full), 0);
      wr_word(pat(10 + DEPTH/2));
      chk(half_full == 1'b1, "R8", 32'(half_full), 1);
      for (int i = DEPTH/2 + 1; i < DEPTH; i++) wr_word(pat(10 + i));
      chk(wr_stat == 1'b1, "R5", 32'(wr_stat), 1);
      wr_word(18'h3FFFF);
      settle();
      chk(wr_level == DEPTH, "R6", 32'(wr_level), DEPTH);
      for (int i = 0; i < DEPTH; i++) begin
         rd_pulse();
         chk(dout == pat(10 + i), "R6", 32'(dout), 32'(pat(10 + i)));
      end
      settle();
      chk(rd_stat == 1'b1, "R6", 32'(rd_stat), 1);

      // R5 / R3: fall-through mode
      do_mrst(1'b1);
      chk(rd_stat == 1'b0, "R9", 32'(rd_stat), 0);
      chk(wr_stat == 1'b1, "R5", 32'(wr_stat), 1);
      @(negedge wclk); wr_en_n = 1'b0; din = pat(50);
      @(posedge wclk); #1 wr_en_n = 1'b1;
      n = 0;
      for (int k = 1; k <= 8; k++) begin
         @(posedge rclk); #1;
         n = k;
         if (rd_stat) break;
      end
      chk(n == 3, "R3", 32'(n), 3);
      chk(dout == pat(50), "R3", 32'(dout), 32'(pat(50)));

      // R4: hold until consumed
      wr_word(pat(51));
      wr_word(pat(52));
      settle();
      chk(dout == pat(50) && rd_stat, "R4", 32'(dout), 32'(pat(50)));
      rd_pulse();
      chk(dout == pat(51), "R4", 32'(dout), 32'(pat(51)));
      rd_pulse();
      chk(dout == pat(52), "R4", 32'(dout), 32'(pat(52)));
      rd_pulse();
      chk(rd_stat == 1'b0, "R4", 32'(rd_stat), 0);

      // R10 / R1: partial reset keeps fall-through mode
      wr_word(pat(60));
      wr_word(pat(61));
      settle();
      do_prst(1'b0);
      chk(rd_stat == 1'b0, "R10", 32'(rd_stat), 0);
      chk(wr_level == 0, "R10", 32'(wr_level), 0);
      chk(wr_stat == 1'b1, "R10", 32'(wr_stat), 1);
      wr_word(pat(62));
      settle();
      chk(rd_stat == 1'b1 && dout == pat(62), "R1", 32'(dout), 32'(pat(62)));

      // R11: retransmit in standard mode
      do_mrst(1'b0);
      for (int i = 0; i < 4; i++) wr_word(pat(70 + i));
      settle();
      for (int i = 0; i < 2; i++) begin
         rd_pulse();
         chk(dout == pat(70 + i), "R11", 32'(dout), 32'(pat(70 + i)));
      end
      @(negedge rclk); rt_n = 1'b0;
      @(negedge rclk); rt_n = 1'b1;
      settle();
      chk(rd_level == 4, "R11", 32'(rd_level), 4);
      for (int i = 0; i < 4; i++) begin
         rd_pulse();
         chk(dout == pat(70 + i), "R11", 32'(dout), 32'(pat(70 + i)));
      end

      // R9: master reset with data stored
      for (int i = 0; i < 3; i++) wr_word(pat(80 + i));
      settle();
      do_mrst(1'b0);
      chk(rd_stat == 1'b1, "R9", 32'(rd_stat), 1);
      chk(wr_level == 0 && rd_level == 0, "R9", 32'(rd_level), 0);

      // random traffic in both modes
      rand_run(1'b0);
      do_mrst(1'b1);
      rand_run(1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule